// File: doc/BRIEF.md
# Fractional Divider Register Bank

This block is a byte-wide register file for the feedback divider of a PLL. It holds one 18-bit signed fraction numerator for each of two selectable profiles. It also holds one configuration byte with an input-clock select bit and a VCO range code for each profile. A host writes bytes over a plain address/data/write-strobe bus. Each fraction is spread over three byte registers. The two upper bytes only load staging copies. Writing the low byte moves the whole value into the committed register as one atomic update.

The committed numerator A is two's complement. The divider's fractional part is A / 2^18, which spans roughly -0.5 to +0.5. A profile-select input picks which committed fraction and which decoded range class drive the selected outputs. Every byte address can be read back at once through a combinational read port.

Top module: `frac_bank`

## Requirements
- R1: Profile p's bytes sit at addresses 22h + 5·p (upper), 23h + 5·p (middle) and 24h + 5·p (low). The upper byte carries fraction bits 17:16 in data bits 1:0, the middle byte carries bits 15:8 and the low byte carries bits 7:0. The fraction is a two's-complement numerator, so an upper byte of 02h with zero lower bytes gives -2^17 (20000h).
- R2: A write to a profile's upper or middle byte changes only that staging byte. The committed fraction stays unchanged.
- R3: A write to a profile's low byte commits {staged upper bits, staged middle byte, written data}. All 18 bits appear together on the fraction outputs after that clock edge.
- R4: Address 21h is the configuration byte. Bit 7 drives the input-select output (0 = reference input, 1 = second PLL's output). Bits 6:5 hold profile 0's range code and bits 4:3 hold profile 1's.
- R5: Each range code is decoded to a 2-bit class: code 00 gives class 0 (below 300 MHz), code 01 gives class 1 (300 to below 370 MHz), and codes 10 and 11 both give class 2 (370 MHz and above). Profile p's class is at range_all_o[2p+1:2p].
- R6: The select input chooses which profile's committed fraction and range class appear on frac_sel_o and range_sel_o.
- R7: Unused data bits are ignored: bits 7:2 of an upper byte and bits 2:0 of the configuration byte read back as zero and affect no output.
- R8: Writes to any address other than 21h–24h and 27h–29h change no output and no readback value.
- R9: rd_data returns, in the same cycle, the staging byte for a profile address, the configuration byte for 21h, and zero for all other addresses.
- R10: A synchronous active-high reset clears every staging, committed and configuration register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 8 | Readback address |
| rd_data | output | 8 | Readback byte (combinational) |
| prof_sel | input | 1 | Profile select |
| frac_all_o | output | 36 | Committed fractions, profile p at bits 18p+17:18p |
| frac_sel_o | output | 18 | Committed fraction of the selected profile |
| in_sel_o | output | 1 | PLL input-mux select |
| range_all_o | output | 4 | Decoded range class per profile |
| range_sel_o | output | 2 | Decoded range class of the selected profile |

## Verification
The bench builds the block with its default parameters: two profiles, an 18-bit fraction and byte-wide data and addresses. With these values the 2-bit upper field, the masked configuration bits and the gap at 25h–26h between the two profiles are all present, so masking and unmapped holes can be checked at the ports. Writes are aimed at a window from 1Eh to 2Dh. This reaches every mapped byte, both neighbouring gaps and out-of-order byte sequences, which check that a partial upper-byte update commits only on the next low-byte write. A mid-run reset and directed writes cover the most negative fraction and the 10/11 range aliasing.

// File: rtl/frac_bank_pkg.sv
package frac_bank_pkg;

   typedef enum logic [1:0] {
      RC_BELOW_LOW = 2'd0,
      RC_MIDBAND   = 2'd1,
      RC_HIGHBAND  = 2'd2
   } range_cls_e;

   function automatic range_cls_e range_decode(input logic [1:0] code);
      range_cls_e cls;
      if (code[1])      cls = RC_HIGHBAND;
      else if (code[0]) cls = RC_MIDBAND;
      else              cls = RC_BELOW_LOW;
      return cls;
   endfunction

endpackage

// File: rtl/frac_bank_profile.sv
module frac_bank_profile #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8,
   parameter int FRAC_W = 18,
   parameter logic [ADDR_W-1:0] BASE = 8'h22
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_byte,
   output logic [FRAC_W-1:0] frac_o
);
   localparam int HI_W = FRAC_W - 2*DATA_W;
   localparam logic [DATA_W-1:0] HI_MASK = DATA_W'((1 << HI_W) - 1);
   localparam logic [ADDR_W-1:0] A_HI  = BASE;
   localparam logic [ADDR_W-1:0] A_MID = BASE + ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_LO  = BASE + ADDR_W'(2);

   logic [DATA_W-1:0] stage_hi, stage_mid, stage_lo;
   logic [FRAC_W-1:0] frac_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         stage_hi  <= '0;
         stage_mid <= '0;
         stage_lo  <= '0;
         frac_q    <= '0;
      end else if (wr_en) begin
         if (wr_addr == A_HI)  stage_hi  <= wr_data & HI_MASK;
         if (wr_addr == A_MID) stage_mid <= wr_data;
         if (wr_addr == A_LO) begin
            stage_lo <= wr_data;
            frac_q   <= {stage_hi[HI_W-1:0], stage_mid, wr_data};
         end
      end
   end

   always_comb begin
      if (rd_addr == A_HI)       rd_byte = stage_hi;
      else if (rd_addr == A_MID) rd_byte = stage_mid;
      else if (rd_addr == A_LO)  rd_byte = stage_lo;
      else                       rd_byte = '0;
   end

   assign frac_o = frac_q;

   assert_commit_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_addr == A_LO) |=> $stable(frac_o))
      else $error("committed fraction moved without a low-byte write");

   assert_commit_low_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == A_LO) |=> frac_o[DATA_W-1:0] == $past(wr_data))
      else $error("low byte not committed");

   assert_stage_hi_mask_R7: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == A_HI) |=> (stage_hi & ~HI_MASK) == '0)
      else $error("unused upper-byte bits stored");

endmodule

// File: rtl/frac_bank_cfg.sv
module frac_bank_cfg #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 8,
   parameter int NUM_PROF = 2,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h21
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic [DATA_W-1:0]     rd_byte,
   output logic                  in_sel_o,
   output logic [2*NUM_PROF-1:0] codes_o
);
   function automatic logic [DATA_W-1:0] cfg_mask();
      logic [DATA_W-1:0] m;
      m = '0;
      m[DATA_W-1] = 1'b1;
      for (int p = 0; p < NUM_PROF; p++) begin
         m[DATA_W-2-2*p] = 1'b1;
         m[DATA_W-3-2*p] = 1'b1;
      end
      return m;
   endfunction

   localparam logic [DATA_W-1:0] MASK = cfg_mask();

   logic [DATA_W-1:0] cfg_q;

   always_ff @(posedge clk) begin
      if (rst)                             cfg_q <= '0;
      else if (wr_en && wr_addr == CFG_ADDR) cfg_q <= wr_data & MASK;
   end

   for (genvar p = 0; p < NUM_PROF; p++) begin : g_code
      assign codes_o[2*p +: 2] = cfg_q[DATA_W-2-2*p -: 2];
   end

   assign in_sel_o = cfg_q[DATA_W-1];
   assign rd_byte  = (rd_addr == CFG_ADDR) ? cfg_q : '0;

   assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_addr == CFG_ADDR) |=> $stable(cfg_q))
      else $error("config changed without a config write");

   assert_cfg_insel_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == CFG_ADDR) |=> in_sel_o == $past(wr_data[DATA_W-1]))
      else $error("input select not loaded");

endmodule

// File: rtl/frac_bank.sv
module frac_bank
   import frac_bank_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 8,
   parameter int FRAC_W      = 18,
   parameter int NUM_PROF    = 2,
   parameter int PROF_BASE   = 'h22,
   parameter int PROF_STRIDE = 5,
   parameter int CFG_ADDR    = 'h21,
   localparam int PSEL_W     = $clog2(NUM_PROF)
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [DATA_W-1:0]          rd_data,
   input  logic [PSEL_W-1:0]          prof_sel,
   output logic [NUM_PROF*FRAC_W-1:0] frac_all_o,
   output logic [FRAC_W-1:0]          frac_sel_o,
   output logic                       in_sel_o,
   output logic [2*NUM_PROF-1:0]      range_all_o,
   output logic [1:0]                 range_sel_o
);
   if (FRAC_W <= 2*DATA_W || FRAC_W > 3*DATA_W) begin : g_bad_frac
      $error("FRAC_W must fit in three bytes with a non-empty upper byte");
   end
   if (NUM_PROF < 2 || 2*NUM_PROF + 1 > DATA_W) begin : g_bad_prof
      $error("NUM_PROF range codes must fit in the config byte");
   end
   if (PROF_STRIDE < 3) begin : g_bad_stride
      $error("profile byte groups must not overlap");
   end

   logic [DATA_W-1:0] rd_prof [NUM_PROF];
   logic [DATA_W-1:0] rd_cfg;
   logic [2*NUM_PROF-1:0] codes;

   for (genvar p = 0; p < NUM_PROF; p++) begin : g_prof
      frac_bank_profile #(
         .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W),
         .BASE(ADDR_W'(PROF_BASE + p*PROF_STRIDE))
      ) prof_i (
         .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
         .wr_data(wr_data), .rd_addr(rd_addr), .rd_byte(rd_prof[p]),
         .frac_o(frac_all_o[p*FRAC_W +: FRAC_W])
      );
      assign range_all_o[2*p +: 2] = range_decode(codes[2*p +: 2]);
   end

   frac_bank_cfg #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_PROF(NUM_PROF),
      .CFG_ADDR(ADDR_W'(CFG_ADDR))
   ) cfg_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_byte(rd_cfg),
      .in_sel_o(in_sel_o), .codes_o(codes)
   );

   always_comb begin
      rd_data = rd_cfg;
      for (int p = 0; p < NUM_PROF; p++) rd_data = rd_data | rd_prof[p];
   end

   always_comb begin
      frac_sel_o  = frac_all_o[0 +: FRAC_W];
      range_sel_o = range_all_o[1:0];
      for (int p = 1; p < NUM_PROF; p++) begin
         if (int'(prof_sel) == p) begin
            frac_sel_o  = frac_all_o[p*FRAC_W +: FRAC_W];
            range_sel_o = range_all_o[2*p +: 2];
         end
      end
   end

   assert_reset_clear_R10: assert property (@(posedge clk)
      rst |=> (frac_all_o == '0 && !in_sel_o && range_all_o == '0))
      else $error("reset did not clear the bank");

   assert_class_legal_R5: assert property (@(posedge clk) disable iff (rst)
      range_sel_o != 2'd3)
      else $error("illegal range class");

endmodule

// File: tb/frac_bank_tb_top.sv
module frac_bank_tb_top;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic wr_en = 1'b0;
   logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
   logic [7:0] rd_data;
   logic prof_sel = 1'b0;
   logic [35:0] frac_all_o;
   logic [17:0] frac_sel_o;
   logic in_sel_o;
   logic [3:0] range_all_o;
   logic [1:0] range_sel_o;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   logic [7:0]  m_stage [2][3];
   logic [17:0] m_frac [2];
   logic [7:0]  m_cfg;

   always #2.5 clk = ~clk;

   frac_bank dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .prof_sel(prof_sel),
      .frac_all_o(frac_all_o), .frac_sel_o(frac_sel_o), .in_sel_o(in_sel_o),
      .range_all_o(range_all_o), .range_sel_o(range_sel_o)
   );

   function automatic logic [1:0] exp_cls(input logic [1:0] code);
      return code[1] ? 2'd2 : code;
   endfunction

   function automatic logic [7:0] exp_rd(input logic [7:0] a);
      logic [7:0] r;
      r = 8'h00;
      if (a == 8'h21) r = m_cfg;
      for (int p = 0; p < 2; p++)
         for (int b = 0; b < 3; b++)
            if (a == 8'(8'h22 + 5*p + b)) r = m_stage[p][b];
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int p = 0; p < 2; p++) begin
         m_frac[p] = '0;
         for (int b = 0; b < 3; b++) m_stage[p][b] = '0;
      end
      m_cfg = '0;
   endtask

   task automatic model_write(input logic [7:0] a, input logic [7:0] d);
      for (int p = 0; p < 2; p++) begin
         if (a == 8'(8'h22 + 5*p)) m_stage[p][0] = d & 8'h03;
         if (a == 8'(8'h23 + 5*p)) m_stage[p][1] = d;
         if (a == 8'(8'h24 + 5*p)) begin
            m_frac[p] = {m_stage[p][0][1:0], m_stage[p][1], d};
            m_stage[p][2] = d;
         end
      end
      if (a == 8'h21) m_cfg = d & 8'hF8;
   endtask

   task automatic check_all();
      logic [1:0] c0, c1;
      c0 = exp_cls(m_cfg[6:5]);
      c1 = exp_cls(m_cfg[4:3]);
      chk("R3 frac0", 32'(frac_all_o[17:0]), 32'(m_frac[0]));
      chk("R3 frac1", 32'(frac_all_o[35:18]), 32'(m_frac[1]));
      chk("R6 frac_sel", 32'(frac_sel_o), 32'(m_frac[prof_sel]));
      chk("R4 in_sel", 32'(in_sel_o), 32'(m_cfg[7]));
      chk("R5 range_all", 32'(range_all_o), 32'({c1, c0}));
      chk("R6 range_sel", 32'(range_sel_o), 32'(prof_sel ? c1 : c0));
      chk("R9 rd_data", 32'(rd_data), 32'(exp_rd(rd_addr)));
   endtask

   task automatic step(input logic r, input logic we, input logic [7:0] a,
                       input logic [7:0] d, input logic [7:0] ra, input logic ps);
      rst = r; wr_en = we; wr_addr = a; wr_data = d; rd_addr = ra; prof_sel = ps;
      @(posedge clk);
      if (r) model_clear();
      else if (we) model_write(a, d);
      @(negedge clk);
      check_all();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int seed;
      seed = $urandom(32'h5EED_0042);
      model_clear();
      @(negedge clk);
      step(1'b1, 1'b0, 8'h00, 8'h00, 8'h22, 1'b0);
      step(1'b1, 1'b0, 8'h00, 8'h00, 8'h21, 1'b0);
      // R10: everything clear after reset
      chk("R10 frac_all", 32'(frac_all_o != 0), 32'd0);
      chk("R10 rd 21h", 32'(rd_data), 32'd0);

      // R7 / R2: upper and middle bytes stage only
      step(1'b0, 1'b1, 8'h22, 8'hFF, 8'h22, 1'b0);
      chk("R7 upper mask readback", 32'(rd_data), 32'h03);
      step(1'b0, 1'b1, 8'h23, 8'hAB, 8'h23, 1'b0);
      chk("R2 commit unchanged", 32'(frac_all_o[17:0]), 32'd0);
      // R3 / R1: low byte commits all 18 bits
      step(1'b0, 1'b1, 8'h24, 8'h00, 8'h24, 1'b0);
      chk("R3 atomic commit", 32'(frac_all_o[17:0]), 32'h3AB00);
      // R1: most negative fraction on profile 1
      step(1'b0, 1'b1, 8'h27, 8'h02, 8'h27, 1'b1);
      step(1'b0, 1'b1, 8'h28, 8'h00, 8'h28, 1'b1);
      chk("R2 profile1 unchanged", 32'(frac_sel_o), 32'd0);
      step(1'b0, 1'b1, 8'h29, 8'h00, 8'h29, 1'b1);
      chk("R1 most negative", 32'(frac_sel_o), 32'h20000);
      chk("R1 sign", 32'($signed(frac_sel_o) < 0), 32'd1);
      // R4 / R5 / R7: config byte, 10 and 11 alias, low bits dropped
      step(1'b0, 1'b1, 8'h21, 8'hDF, 8'h21, 1'b0);
      chk("R4 in_sel", 32'(in_sel_o), 32'd1);
      chk("R5 code10", 32'(range_all_o[1:0]), 32'd2);
      chk("R5 code11", 32'(range_all_o[3:2]), 32'd2);
      chk("R7 cfg mask", 32'(rd_data), 32'hD8);
      step(1'b0, 1'b1, 8'h21, 8'h28, 8'h21, 1'b1);
      chk("R5 code01", 32'(range_all_o[1:0]), 32'd1);
      chk("R6 range_sel", 32'(range_sel_o), 32'd1);
      // R8: unmapped writes ignored
      step(1'b0, 1'b1, 8'h25, 8'hFF, 8'h25, 1'b0);
      chk("R8 gap readback", 32'(rd_data), 32'd0);
      step(1'b0, 1'b1, 8'h20, 8'hFF, 8'h21, 1'b0);
      chk("R8 cfg kept", 32'(rd_data), 32'h28);
      chk("R8 frac kept", 32'(frac_all_o), 32'(36'h80003AB00));

      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] a, d, ra;
         a  = 8'(8'h1E + $urandom % 16);
         d  = 8'($urandom);
         ra = 8'(8'h1E + $urandom % 16);
         step(i == 2000, ($urandom % 4) != 0, a, d, ra, 1'($urandom));
      end
      // R10 reset mid-run clears all
      step(1'b1, 1'b0, 8'h00, 8'h00, 8'h23, 1'b1);
      chk("R10 mid reset", 32'(frac_all_o != 0), 32'd0);
      finish_run();
   end
endmodule